// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor request port and a lower-level memory port. It splits each word address into a tag, a set index and a word offset. It reads the two entries of the indexed set together and compares both stored tags with the address tag at the same time. A hit completes in the cycle the request is presented. On a miss, the controller chooses a victim way. If that victim holds modified data, the controller writes the whole line back. It then fetches the missing line as one wide transfer and finishes the original access.

The write-miss policy is a static configuration input. With allocation enabled, a write miss refills the line and then stores into it like a write hit. With allocation disabled, the write goes straight to memory as a single word, and the cache contents and replacement state are left untouched. Both ports use a hold-until-ready handshake. The processor keeps its request stable until `cpu_ready` is seen, and the controller keeps its memory request stable until `mem_ready` is seen.

Top module: `twoway_cache`

## Requirements
- R1: While reset is held and right after it, `cpu_ready` and `mem_req` are low and every entry is invalid, so the first access to any line misses.
- R2: The word address splits into the offset in the low log2(WORDS) bits, the set index in the next log2(SETS) bits and the tag in the remaining upper bits. Capacity is 2 × SETS × WORDS words, and lines with equal index but different tags share one set.
- R3: Hit is the OR of the two valid-qualified tag compares. A hit raises `cpu_ready` and `cpu_hit` in the same cycle as the request, with no memory traffic.
- R4: On a read, `cpu_rdata` is the word chosen by the offset from the way that matched, or from the refilled way on a miss.
- R5: A write hit updates only the cached word and marks the line dirty. No memory write occurs.
- R6: The victim is way 0 if it is invalid, else way 1 if it is invalid, else the way named by the set's LRU bit. The LRU bit points away from the way last touched by a hit or a refill.
- R7: A victim that is valid and dirty is written back as a full line, with all word enables set, before the refill starts. A clean victim causes no memory write.
- R8: With `cfg_wr_alloc`=1, a write miss refills the line and then writes the word. It completes with `cpu_ready`=1 and `cpu_hit`=0 in the cycle after the refill data arrives.
- R9: With `cfg_wr_alloc`=0, a write miss issues one memory write with exactly one bit of `mem_wsel` set, at the offset position, and leaves the cache unchanged.
- R10: `cpu_ready` stays low through the whole miss sequence (write-back, refill, then completion). `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ready`.
- R11: From an empty cache, the stream write X, write X, read Y, write Y, write X (X and Y in different lines) gives 4 misses and 1 hit without allocation, and 2 misses and 3 hits with allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_alloc | input | 1 | 1 = allocate on write miss, 0 = write around |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_hit | output | 1 | Completing access was a hit |
| cpu_rdata | output | DATA_W | Load data, valid with ready on reads |
| mem_req | output | 1 | Memory transfer request, held until ready |
| mem_we | output | 1 | 1 = memory write, 0 = line read |
| mem_addr | output | ADDR_W | Word address; line aligned except for single-word writes |
| mem_wsel | output | WORDS | Word enables of a memory write |
| mem_wline | output | WORDS*DATA_W | Line data for memory writes |
| mem_ready | input | 1 | Memory transfer completes this cycle |
| mem_rline | input | WORDS*DATA_W | Line data returned by a read |

## Verification
The assertions check the handshake rules on every cycle. They confirm that a hit completes with no memory request, that memory requests stay stable until accepted, and that a full-line write-back is always followed by a refill read. They also confirm that a single-word memory write appears only without allocation, and that a refill is followed by a miss completion. Other behaviour can only be shown by the bench's scenarios, because it depends on stored state across many accesses. This covers the data values returned after refills and evictions, and whether a victim is written back according to its dirty bit. It also covers the LRU choice between two valid ways and the hit and miss counts of the reference access stream under each policy.

// File: rtl/twc_pkg.sv
package twc_pkg;
   localparam int WAYS = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WBACK,
      ST_FILL,
      ST_DONE,
      ST_NWRITE
   } twc_state_e;
endpackage

// File: rtl/twc_tag_store.sv
module twc_tag_store #(
   parameter int SETS  = 4,
   parameter int TAG_W = 12,
   parameter int IDX_W = $clog2(SETS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [IDX_W-1:0]      idx,
   input  logic [TAG_W-1:0]      cmp_tag,
   input  logic                  fill_en,
   input  logic                  fill_way,
   input  logic                  mark_en,
   input  logic                  mark_way,
   input  logic                  touch_en,
   input  logic                  touch_way,
   output logic [1:0]            set_vld,
   output logic [1:0]            set_dirty,
   output logic [1:0]            hit_vec,
   output logic [1:0][TAG_W-1:0] set_tag,
   output logic                  set_lru
);
   logic [SETS-1:0] lru_q;

   genvar w;
   generate
      for (w = 0; w < twc_pkg::WAYS; w++) begin : g_way
         logic [SETS-1:0]  vld_q;
         logic [SETS-1:0]  dirty_q;
         logic [TAG_W-1:0] tag_q [SETS];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q   <= '0;
               dirty_q <= '0;
            end else begin
               if (fill_en && (fill_way == 1'(w))) begin
                  vld_q[idx]   <= 1'b1;
                  dirty_q[idx] <= 1'b0;
               end
               if (mark_en && (mark_way == 1'(w)))
                  dirty_q[idx] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (fill_en && (fill_way == 1'(w)))
               tag_q[idx] <= cmp_tag;
         end

         assign set_vld[w]   = vld_q[idx];
         assign set_dirty[w] = dirty_q[idx];
         assign set_tag[w]   = tag_q[idx];
         assign hit_vec[w]   = vld_q[idx] && (tag_q[idx] == cmp_tag);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lru_q <= '0;
      else if (touch_en)
         lru_q[idx] <= ~touch_way;
   end

   assign set_lru = lru_q[idx];
endmodule

// File: rtl/twc_data_store.sv
module twc_data_store #(
   parameter int SETS   = 4,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   parameter int IDX_W  = $clog2(SETS),
   parameter int LINE_W = WORDS * DATA_W
) (
   input  logic                   clk,
   input  logic [IDX_W-1:0]       idx,
   input  logic [1:0]             wr_en,
   input  logic [WORDS-1:0]       wr_mask,
   input  logic [LINE_W-1:0]      wr_line,
   output logic [1:0][LINE_W-1:0] rd_line
);
   genvar w;
   generate
      for (w = 0; w < twc_pkg::WAYS; w++) begin : g_way
         logic [LINE_W-1:0] line_q [SETS];

         always_ff @(posedge clk) begin
            if (wr_en[w]) begin
               for (int k = 0; k < WORDS; k++) begin
                  if (wr_mask[k])
                     line_q[idx][k*DATA_W +: DATA_W] <= wr_line[k*DATA_W +: DATA_W];
               end
            end
         end

         assign rd_line[w] = line_q[idx];
      end
   endgenerate
endmodule

// File: rtl/twoway_cache.sv
module twoway_cache #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   parameter int SETS   = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_wr_alloc,
   input  logic                    cpu_req,
   input  logic                    cpu_we,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic [DATA_W-1:0]       cpu_wdata,
   output logic                    cpu_ready,
   output logic                    cpu_hit,
   output logic [DATA_W-1:0]       cpu_rdata,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [WORDS-1:0]        mem_wsel,
   output logic [WORDS*DATA_W-1:0] mem_wline,
   input  logic                    mem_ready,
   input  logic [WORDS*DATA_W-1:0] mem_rline
);
   import twc_pkg::*;

   localparam int OFF_W  = $clog2(WORDS);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int LINE_W = WORDS * DATA_W;

   generate
      if ((SETS < 2) || ((SETS & (SETS - 1)) != 0)) begin : g_bad_sets
         $error("twoway_cache: SETS must be a power of two of at least 2");
      end
      if ((WORDS < 2) || ((WORDS & (WORDS - 1)) != 0)) begin : g_bad_words
         $error("twoway_cache: WORDS must be a power of two of at least 2");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("twoway_cache: ADDR_W too small for SETS and WORDS");
      end
   endgenerate

   twc_state_e st_q, st_nx;
   logic [ADDR_W-1:0] q_addr;
   logic              q_we;
   logic [DATA_W-1:0] q_wdata;
   logic              q_way;

   logic [ADDR_W-1:0] cur_addr;
   logic              cur_we;
   logic [DATA_W-1:0] cur_wdata;
   logic [OFF_W-1:0]  cur_off;
   logic [IDX_W-1:0]  cur_idx;
   logic [TAG_W-1:0]  cur_tag;

   logic [1:0]             set_vld, set_dirty, hit_vec;
   logic [1:0][TAG_W-1:0]  set_tag;
   logic                   set_lru;
   logic                   hit, hit_way, victim, acc_way;
   logic                   fill_en, mark_en, touch_en, touch_way;
   logic [1:0]             dwr_en;
   logic [WORDS-1:0]       dwr_mask, off_onehot;
   logic [LINE_W-1:0]      dwr_line, acc_line;
   logic [1:0][LINE_W-1:0] rd_line;

   // In IDLE the live request is looked up; during a miss the latched copy is.
   assign cur_addr  = (st_q == ST_IDLE) ? cpu_addr  : q_addr;
   assign cur_we    = (st_q == ST_IDLE) ? cpu_we    : q_we;
   assign cur_wdata = (st_q == ST_IDLE) ? cpu_wdata : q_wdata;
   assign cur_off   = cur_addr[OFF_W-1:0];
   assign cur_idx   = cur_addr[OFF_W +: IDX_W];
   assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];

   twc_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (cur_idx),
      .cmp_tag   (cur_tag),
      .fill_en   (fill_en),
      .fill_way  (q_way),
      .mark_en   (mark_en),
      .mark_way  (acc_way),
      .touch_en  (touch_en),
      .touch_way (touch_way),
      .set_vld   (set_vld),
      .set_dirty (set_dirty),
      .hit_vec   (hit_vec),
      .set_tag   (set_tag),
      .set_lru   (set_lru)
   );

   twc_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W),
                    .LINE_W(LINE_W)) u_data (
      .clk     (clk),
      .idx     (cur_idx),
      .wr_en   (dwr_en),
      .wr_mask (dwr_mask),
      .wr_line (dwr_line),
      .rd_line (rd_line)
   );

   assign hit     = |hit_vec;
   assign hit_way = hit_vec[1];
   assign acc_way = (st_q == ST_IDLE) ? hit_way : q_way;

   always_comb begin
      if (!set_vld[0])      victim = 1'b0;
      else if (!set_vld[1]) victim = 1'b1;
      else                  victim = set_lru;
   end

   always_comb begin
      off_onehot          = '0;
      off_onehot[cur_off] = 1'b1;
   end

   assign acc_line  = rd_line[acc_way];
   assign cpu_rdata = acc_line[cur_off*DATA_W +: DATA_W];

   always_comb begin
      st_nx     = st_q;
      cpu_ready = 1'b0;
      cpu_hit   = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = {cur_tag, cur_idx, {OFF_W{1'b0}}};
      mem_wsel  = '0;
      mem_wline = rd_line[q_way];
      fill_en   = 1'b0;
      mark_en   = 1'b0;
      touch_en  = 1'b0;
      touch_way = acc_way;
      dwr_en    = '0;
      dwr_mask  = off_onehot;
      dwr_line  = {WORDS{cur_wdata}};
      unique case (st_q)
         ST_IDLE: begin
            if (cpu_req) begin
               if (hit) begin
                  cpu_ready = 1'b1;
                  cpu_hit   = 1'b1;
                  touch_en  = 1'b1;
                  if (cur_we) begin
                     dwr_en[acc_way] = 1'b1;
                     mark_en         = 1'b1;
                  end
               end else if (cur_we && !cfg_wr_alloc) begin
                  st_nx = ST_NWRITE;
               end else if (set_vld[victim] && set_dirty[victim]) begin
                  st_nx = ST_WBACK;
               end else begin
                  st_nx = ST_FILL;
               end
            end
         end
         ST_WBACK: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = {set_tag[q_way], cur_idx, {OFF_W{1'b0}}};
            mem_wsel = '1;
            if (mem_ready) st_nx = ST_FILL;
         end
         ST_FILL: begin
            mem_req = 1'b1;
            if (mem_ready) begin
               fill_en       = 1'b1;
               dwr_en[q_way] = 1'b1;
               dwr_mask      = '1;
               dwr_line      = mem_rline;
               st_nx         = ST_DONE;
            end
         end
         ST_DONE: begin
            cpu_ready = 1'b1;
            touch_en  = 1'b1;
            if (cur_we) begin
               dwr_en[q_way] = 1'b1;
               mark_en       = 1'b1;
            end
            st_nx = ST_IDLE;
         end
         ST_NWRITE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = q_addr;
            mem_wsel  = off_onehot;
            mem_wline = {WORDS{q_wdata}};
            if (mem_ready) begin
               cpu_ready = 1'b1;
               st_nx     = ST_IDLE;
            end
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         q_addr  <= '0;
         q_we    <= 1'b0;
         q_wdata <= '0;
         q_way   <= 1'b0;
      end else begin
         st_q <= st_nx;
         if ((st_q == ST_IDLE) && cpu_req && !hit) begin
            q_addr  <= cpu_addr;
            q_we    <= cpu_we;
            q_wdata <= cpu_wdata;
            q_way   <= victim;
         end
      end
   end
endmodule

// File: rtl/twoway_cache_checker.sv
module twoway_cache_checker #(
   parameter int ADDR_W = 16,
   parameter int WORDS  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr_alloc,
   input logic              cpu_req,
   input logic              cpu_ready,
   input logic              cpu_hit,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [WORDS-1:0]  mem_wsel
);
   // R3 / R5: a hit completes with no memory transfer in flight
   p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && cpu_hit) |-> !mem_req);

   // R1 / R10: completion only answers a pending request
   p_ready_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);

   // R10: memory request holds its command until accepted
   p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

   // R7: a full-line write-back is always followed by the refill read
   p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ready && ($countones(mem_wsel) == WORDS))
      |=> (mem_req && !mem_we));

   // R7 / R9: memory writes are either whole lines or one word
   p_wsel_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (($countones(mem_wsel) == WORDS) || ($countones(mem_wsel) == 1)));

   // R9: single-word writes only happen when allocation is off
   p_word_write_policy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && ($countones(mem_wsel) == 1)) |-> !cfg_wr_alloc);

   // R8: refill completion is reported as a miss in the next cycle
   p_fill_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ready) |=> (cpu_ready && !cpu_hit));
endmodule

bind twoway_cache twoway_cache_checker #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wr_alloc (cfg_wr_alloc),
   .cpu_req      (cpu_req),
   .cpu_ready    (cpu_ready),
   .cpu_hit      (cpu_hit),
   .mem_req      (mem_req),
   .mem_we       (mem_we),
   .mem_ready    (mem_ready),
   .mem_addr     (mem_addr),
   .mem_wsel     (mem_wsel)
);

// File: tb/twoway_cache_bench.sv
module twoway_cache_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int AW  = 16;
   localparam int DW  = 32;
   localparam int NW  = 4;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr_alloc = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic cpu_ready, cpu_hit;
   logic [DW-1:0] cpu_rdata;
   logic mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [NW-1:0] mem_wsel;
   logic [NW*DW-1:0] mem_wline;
   logic mem_ready = 1'b0;
   logic [NW*DW-1:0] mem_rline = '0;

   always #2.5 clk = ~clk;

   twoway_cache #(.ADDR_W(AW), .DATA_W(DW), .WORDS(NW), .SETS(4)) u_twoway_cache (
      .clk(clk), .rst_n(rst_n), .cfg_wr_alloc(cfg_wr_alloc),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wsel(mem_wsel),
      .mem_wline(mem_wline), .mem_ready(mem_ready), .mem_rline(mem_rline));

   int n_chk = 0, n_fail = 0;
   int n_hit = 0, n_miss = 0;
   int line_wr = 0, word_wr = 0;
   bit finished = 1'b0;

   logic [DW-1:0] mem_arr [int];
   logic [DW-1:0] gold [int];

   function automatic logic [DW-1:0] mget(int a);
      if (mem_arr.exists(a)) return mem_arr[a];
      return 32'h5A00_0000 | 32'(a);
   endfunction

   function automatic logic [DW-1:0] gget(int a);
      if (gold.exists(a)) return gold[a];
      return mget(a);
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // Lower memory: fixed latency, line-wide, word enables on writes
   always @(posedge clk) begin
      static int lat = 0;
      if (!rst_n) begin
         lat = 0;
         mem_ready <= 1'b0;
      end else if (mem_req && !mem_ready) begin
         if (lat == LAT) begin
            int base;
            lat = 0;
            mem_ready <= 1'b1;
            base = int'({mem_addr[AW-1:2], 2'b00});
            if (mem_we) begin
               for (int k = 0; k < NW; k++)
                  if (mem_wsel[k]) mem_arr[base + k] = mem_wline[k*DW +: DW];
               if (mem_wsel == '1) line_wr++; else word_wr++;
            end else begin
               for (int k = 0; k < NW; k++) mem_rline[k*DW +: DW] <= mget(base + k);
            end
         end else begin
            lat++;
         end
      end else begin
         mem_ready <= 1'b0;
      end
   end

   typedef struct {
      logic          we;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic          hit;
      string         rq;
   } exp_t;
   exp_t sb [$];

   // Monitor: pops one expected item per completed access
   always @(negedge clk) begin
      if (rst_n && cpu_req && cpu_ready) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R3", "unexpected completion", 32'(cpu_addr), '0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(cpu_hit == e.hit, e.rq, $sformatf("hit flag @%0h", e.a), 32'(cpu_hit), 32'(e.hit));
            if (!e.we)
               chk(cpu_rdata == e.d, "R4", $sformatf("read data @%0h", e.a), cpu_rdata, e.d);
            if (cpu_hit) n_hit++; else n_miss++;
         end
      end
   end

   task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic exp_hit, input string rq, output int waits);
      exp_t e;
      e.we = we; e.a = a; e.hit = exp_hit; e.rq = rq;
      e.d  = gget(int'(a));
      sb.push_back(e);
      if (we) gold[int'(a)] = d;
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      waits = 0;
      forever begin
         @(negedge clk);
         if (cpu_ready) break;
         waits++;
      end
      @(posedge clk); #1;
      cpu_req = 1'b0;
   endtask

   task automatic do_reset(input logic alloc);
      cpu_req = 1'b0;
      rst_n = 1'b0;
      cfg_wr_alloc = alloc;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!cpu_ready && !mem_req, "R1", "outputs idle in reset", {cpu_ready, mem_req}, '0);
      #1 rst_n = 1'b1;
      gold.delete();
      n_hit = 0; n_miss = 0;
   endtask

   localparam logic [AW-1:0] LA = 16'h0100, LB = 16'h0200, LC = 16'h0300;
   localparam logic [AW-1:0] LD = 16'h0404, LE = 16'h0504, LF = 16'h0604;

   initial begin
      int w, lw0, ww0;
      // ---- No-write-allocate reference stream (R11, R9, R5) ----
      do_reset(1'b0);
      @(negedge clk);
      chk(!cpu_ready && !mem_req, "R1", "outputs idle after reset", {cpu_ready, mem_req}, '0);
      access(1, LA, 32'h11, 0, "R1", w);
      access(1, LA, 32'h22, 0, "R9", w);
      access(0, LB, 0,      0, "R11", w);
      access(1, LB, 32'h33, 1, "R5", w);
      access(1, LA, 32'h44, 0, "R9", w);
      chk(n_miss == 4 && n_hit == 1, "R11", "no-alloc miss/hit", 32'(n_miss*16 + n_hit), 32'h41);
      chk(mget(int'(LA)) == 32'h44, "R9", "word written around", mget(int'(LA)), 32'h44);
      chk(word_wr == 3, "R9", "single-word writes", 32'(word_wr), 3);
      chk(line_wr == 0, "R5", "no line write on hit", 32'(line_wr), 0);

      // ---- Write-allocate reference stream (R11, R8) ----
      do_reset(1'b1);
      access(1, LA, 32'h55, 0, "R8", w);
      chk(w >= LAT + 1, "R10", "miss wait cycles", 32'(w), LAT + 1);
      access(1, LA, 32'h66, 1, "R11", w);
      chk(w == 0, "R3", "hit wait cycles", 32'(w), 0);
      access(0, LB, 0,      0, "R11", w);
      access(1, LB, 32'h77, 1, "R5", w);
      access(1, LA, 32'h88, 1, "R11", w);
      chk(n_miss == 2 && n_hit == 3, "R11", "alloc miss/hit", 32'(n_miss*16 + n_hit), 32'h23);
      chk(line_wr == 0, "R8", "no write-back from empty set", 32'(line_wr), 0);
      access(0, LA, 0, 1, "R4", w);

      // ---- Dirty eviction with LRU (R6, R7, R10) ----
      lw0 = line_wr;
      access(0, LC, 0, 0, "R6", w);
      chk(line_wr == lw0 + 1, "R7", "dirty victim written back", 32'(line_wr), 32'(lw0 + 1));
      chk(mget(int'(LB)) == 32'h77, "R7", "write-back data", mget(int'(LB)), 32'h77);
      chk(w >= 2*LAT + 2, "R10", "write-back plus refill wait", 32'(w), 32'(2*LAT + 2));
      access(0, LB, 0, 0, "R6", w);
      chk(mget(int'(LA)) == 32'h88, "R7", "second write-back data", mget(int'(LA)), 32'h88);
      access(0, LC, 0, 1, "R2", w);

      // ---- Clean eviction, invalid-first and LRU in set 1 (R6, R7) ----
      lw0 = line_wr;
      ww0 = word_wr;
      access(0, LD, 0, 0, "R6", w);
      access(0, LE, 0, 0, "R6", w);
      access(0, LD, 0, 1, "R6", w);
      access(0, LF, 0, 0, "R6", w);
      access(0, LD, 0, 1, "R6", w);
      access(0, LE, 0, 0, "R6", w);
      chk(line_wr == lw0 && word_wr == ww0, "R7", "clean victims not written", 32'(line_wr), 32'(lw0));

      // ---- Offset selection and word write inside a line (R2, R4, R5) ----
      for (int k = 0; k < NW; k++) access(0, LE + 16'(k), 0, 1, "R2", w);
      access(1, LE + 16'd2, 32'hCAFE_0002, 1, "R5", w);
      access(0, LE + 16'd2, 0, 1, "R4", w);
      access(0, LE + 16'd1, 0, 1, "R4", w);
      access(0, 16'hF504, 0, 0, "R2", w);
      chk(line_wr == lw0 && word_wr == ww0, "R5", "write hit stays in cache", 32'(line_wr), 32'(lw0));

      // ---- No-alloc write miss leaves cache unchanged (R9) ----
      do_reset(1'b0);
      access(0, LD, 0, 0, "R9", w);
      access(1, LE, 32'h9999, 0, "R9", w);
      access(0, LE, 0, 0, "R9", w);
      access(0, LD, 0, 1, "R9", w);

      repeat (4) @(posedge clk);
      chk(sb.size() == 0, "R3", "scoreboard drained", 32'(sb.size()), 0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R10 watchdog expired: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule